// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and combines them into one request toward a processor. It also reports which request to service first. Each line is fixed at build time as edge-sensitive (a rising edge raises a request) or level-sensitive (a request is raised for as long as the line is high). Requests first pass a synchroniser. They are then latched into a status word. An enable word masks the status word to give the pending word.

The lowest-numbered pending line is reported as a vector number. The vector reads as all ones when nothing is pending. A two-bit master control separately gates two things: whether hardware requests are latched at all, and whether the output line may rise. Software reaches the block through a 32-bit register port with separate read and write strobes.

The register port has no back-pressure and no handshake. A write strobe completes in the cycle it is presented. Read data is valid in the same cycle as the read strobe, and the port is never stalled. Software clears requests through a write-one-to-clear acknowledge word. It changes the enable word through write-one-to-set and write-one-to-clear aliases, so one mask bit can be changed without a read-modify-write.

Top module: `vec_intc`

## Requirements
- R1: After reset the status word, enable word, master control and edge history are zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: The word index is the byte address shifted right by two; index 0 is status, 1 pending, 2 enable, 3 acknowledge, 4 set-enable, 5 clear-enable, 6 vector, 7 master control (bit 0 output gate, bit 1 capture gate, upper bits read zero). `bus_rdata` is valid in the same cycle as `bus_rd`, is zero while `bus_rd` is low, and indices 3, 4 and 5 read as zero.
- R3: While master bit 1 is set, every level-sensitive line that is high after synchronisation sets its status bit on each clock, so an acknowledged line that is still high sets its bit again.
- R4: An edge-sensitive line (its `EDGE_MASK` bit is 1) sets its status bit only on a synchronised low-to-high change seen while master bit 1 is set. Holding the line high does not set the bit again, and a change seen while master bit 1 is clear is lost.
- R5: The pending word reads as status AND enable.
- R6: The vector reads as the index of the lowest-numbered pending bit, or 0xFFFFFFFF when no bit is pending.
- R7: `irq_out` is high exactly when master bit 0 is set and the pending word is nonzero, updating the cycle after the register change.
- R8: A write to the acknowledge index clears each status bit written as one. If a capture lands on the same bit in the same cycle, the bit stays set.
- R9: A write to set-enable ORs the data into the enable word. A write to clear-enable clears each enable bit written as one. A write to the enable index replaces the enable word.
- R10: A write to the status index replaces the status word only while master bit 1 is clear. While master bit 1 is set, the write is ignored.
- R11: Writes to the pending and vector indices and to indices 8 and above change nothing, and reads of indices 8 and above return zero.
- R12: A change on `irq_in` reaches the status word after `SYNC_STAGES` + 1 rising clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address; bits [1:0] ignored |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with `bus_rd` |
| irq_in | input | NUM_IRQ | Interrupt request lines |
| irq_out | output | 1 | Combined request to the processor |

## Verification
An acknowledge write and a hardware capture can land on the same status bit in the same clock. The bench provokes this on a level-sensitive line, which captures on every clock. It also sweeps an acknowledge write across the cycles around a single edge on an edge-sensitive line, so that one offset lands exactly on the capture edge. A behavioural reference model follows the synchroniser delay and the capture-over-acknowledge rule and is compared with `irq_out` and the read data on every clock. Directed checks also confirm the status value after the colliding write with a fixed expected value.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Word offsets inside the register window; the order is the software contract.
  typedef enum logic [2:0] {
    OFS_STATUS = 3'd0,
    OFS_PEND   = 3'd1,
    OFS_EN     = 3'd2,
    OFS_ACK    = 3'd3,
    OFS_SETEN  = 3'd4,
    OFS_CLREN  = 3'd5,
    OFS_VEC    = 3'd6,
    OFS_MASTER = 3'd7
  } vic_ofs_e;

  localparam int MASTER_W       = 2;
  localparam int MASTER_OUT_BIT = 0;
  localparam int MASTER_CAP_BIT = 1;
  localparam int OFS_BITS       = 3;

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign dout = stg[STAGES-1];

endmodule

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int          W         = 32,
  parameter logic [31:0] EDGE_MASK = 32'h0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic         cap_en,
  output logic [W-1:0] set_mask
);

  logic [W-1:0] hist_q;
  logic [W-1:0] raw_set;

  // History follows the lines even while capture is off, so edges then are lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= sync_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_line
    if (EDGE_MASK[i]) begin : g_edge
      assign raw_set[i] = sync_in[i] & ~hist_q[i];
    end else begin : g_level
      assign raw_set[i] = sync_in[i];
    end
  end

  assign set_mask = cap_en ? raw_set : '0;

  AST_EDGE_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_mask & W'(EDGE_MASK) & $past(sync_in)) == '0)); // R4

  AST_NO_CAPTURE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && ($past(set_mask) == '0)) |-> (set_mask == '0)); // R4

endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int N      = 32,
  parameter int DW     = 32,
  parameter int IDX_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [DW-1:0]       wdata,
  input  logic [N-1:0]        cap_set,
  output logic [N-1:0]        status,
  output logic [N-1:0]        enable,
  output logic [MASTER_W-1:0] master
);

  logic [N-1:0]        st_n, en_n;
  logic [MASTER_W-1:0] ms_n;
  logic [N-1:0]        wd;
  logic                hit;
  vic_ofs_e            ofs;

  assign wd  = wdata[N-1:0];
  assign hit = ((wr_idx >> OFS_BITS) == '0);
  assign ofs = vic_ofs_e'(wr_idx[OFS_BITS-1:0]);

  always_comb begin
    st_n = status;
    en_n = enable;
    ms_n = master;
    if (wr_en && hit) begin
      unique case (ofs)
        OFS_STATUS: if (!master[MASTER_CAP_BIT]) st_n = wd;
        OFS_EN:     en_n = wd;
        OFS_ACK:    st_n = status & ~wd;
        OFS_SETEN:  en_n = enable | wd;
        OFS_CLREN:  en_n = enable & ~wd;
        OFS_MASTER: ms_n = wdata[MASTER_W-1:0];
        default:    ;
      endcase
    end
    // Hardware capture is applied last so it beats a same-cycle acknowledge.
    st_n = st_n | cap_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
      master <= '0;
    end else begin
      status <= st_n;
      enable <= en_n;
      master <= ms_n;
    end
  end

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && ofs == OFS_ACK && (cap_set & wd) == '0) |=> ((status & $past(wd)) == '0)); // R8

  AST_CAPTURE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_set != '0) |=> ((status & $past(cap_set)) == $past(cap_set))); // R3

  AST_SETEN_ORS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && ofs == OFS_SETEN) |=> ((enable & $past(wd)) == $past(wd))); // R9

  AST_CLREN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit && ofs == OFS_CLREN) |=> ((enable & $past(wd)) == '0)); // R9

  AST_STATUS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (master[MASTER_CAP_BIT] && !(wr_en && hit && ofs == OFS_ACK))
      |=> ((status & $past(status)) == $past(status))); // R10

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int W  = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  pend,
  output logic [DW-1:0] vec,
  output logic          any
);

  localparam int IW = (W > 1) ? $clog2(W) : 1;

  always_comb begin
    vec = '1;
    for (int i = W - 1; i >= 0; i--) begin
      if (pend[i]) vec = DW'(i);
    end
  end

  assign any = |pend;

  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (vec == '1)); // R6

  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (vec != '1) |-> (pend[vec[IW-1:0]] &&
                     ((pend & ((W'(1) << vec[IW-1:0]) - W'(1))) == '0))); // R6

endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
#(
  parameter int          NUM_IRQ     = 32,
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [31:0] EDGE_MASK   = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_in,
  output logic              irq_out
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]    idx;
  logic                hit;
  vic_ofs_e            ofs;
  logic [1:0]          unused_addr_lsb;
  logic [NUM_IRQ-1:0]  sync_q, cap_set, status, enable, pend;
  logic [MASTER_W-1:0] master;
  logic [DATA_W-1:0]   vec;
  logic                any_pend;

  assign idx             = bus_addr[ADDR_W-1:2];
  assign unused_addr_lsb = bus_addr[1:0];
  assign hit             = ((idx >> OFS_BITS) == '0);
  assign ofs             = vic_ofs_e'(idx[OFS_BITS-1:0]);

  vic_sync #(.W(NUM_IRQ), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(sync_q)
  );

  vic_capture #(.W(NUM_IRQ), .EDGE_MASK(EDGE_MASK)) u_cap (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_q),
    .cap_en(master[MASTER_CAP_BIT]), .set_mask(cap_set)
  );

  vic_regs #(.N(NUM_IRQ), .DW(DATA_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_idx(idx), .wdata(bus_wdata),
    .cap_set(cap_set), .status(status), .enable(enable), .master(master)
  );

  assign pend = status & enable;

  vic_prio #(.W(NUM_IRQ), .DW(DATA_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .pend(pend), .vec(vec), .any(any_pend)
  );

  assign irq_out = master[MASTER_OUT_BIT] & any_pend;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd && hit) begin
      unique case (ofs)
        OFS_STATUS: bus_rdata[NUM_IRQ-1:0]  = status;
        OFS_PEND:   bus_rdata[NUM_IRQ-1:0]  = pend;
        OFS_EN:     bus_rdata[NUM_IRQ-1:0]  = enable;
        OFS_VEC:    bus_rdata               = vec;
        OFS_MASTER: bus_rdata[MASTER_W-1:0] = master;
        default:    ;
      endcase
    end
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (vec != '1)); // R7

  AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !hit) |-> (bus_rdata == '0)); // R11

endmodule

// File: tb/vec_intc_tb_top.sv
module vec_intc_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int          N  = 32;
  localparam int          DW = 32;
  localparam int          AW = 8;
  localparam int          SY = 2;
  localparam logic [31:0] EM = 32'hFFFF_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [N-1:0]  irq_in = '0;
  logic          irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  vec_intc #(.NUM_IRQ(N), .DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(SY), .EDGE_MASK(EM)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_in(irq_in), .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [N-1:0] m_sync [SY];
  logic [N-1:0] m_prev, m_stat, m_en;
  logic [1:0]   m_mer;

  always @(posedge clk) begin : model
    logic [N-1:0] cap, ns, ne;
    logic [1:0]   nm;
    int           widx;
    if (!rst_n) begin
      for (int s = 0; s < SY; s++) m_sync[s] = '0;
      m_prev = '0; m_stat = '0; m_en = '0; m_mer = '0;
    end else begin
      cap = '0;
      if (m_mer[1]) begin
        for (int i = 0; i < N; i++) begin
          if (EM[i]) cap[i] = m_sync[SY-1][i] && !m_prev[i];
          else       cap[i] = m_sync[SY-1][i];
        end
      end
      ns = m_stat; ne = m_en; nm = m_mer;
      widx = int'(addr) / 4;
      if (wr) begin
        case (widx)
          0: if (!m_mer[1]) ns = wdata;
          2: ne = wdata;
          3: ns = m_stat & ~wdata;
          4: ne = m_en | wdata;
          5: ne = m_en & ~wdata;
          7: nm = wdata[1:0];
          default: ;
        endcase
      end
      m_stat = ns | cap;
      m_en   = ne;
      m_mer  = nm;
      m_prev = m_sync[SY-1];
      for (int s = SY - 1; s > 0; s--) m_sync[s] = m_sync[s-1];
      m_sync[0] = irq_in;
    end
  end

  function automatic logic [DW-1:0] exp_vec();
    logic [N-1:0] p = m_stat & m_en;
    for (int i = 0; i < N; i++) if (p[i]) return DW'(i);
    return '1;
  endfunction

  function automatic logic [DW-1:0] exp_read(int widx);
    case (widx)
      0: return m_stat;
      1: return m_stat & m_en;
      2: return m_en;
      6: return exp_vec();
      7: return {30'b0, m_mer};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(int widx);
    case (widx)
      0: return "R10";
      1: return "R5";
      2: return "R9";
      6: return "R6";
      7: return "R2";
      default: return "R11";
    endcase
  endfunction

  // Every clock: output line and any read against the model (R7, read path)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic exp_irq;
      exp_irq = m_mer[0] && ((m_stat & m_en) != '0);
      checks++;
      if (irq_out !== exp_irq) begin
        errors++;
        $display("FAIL R7: irq_out got %b exp %b at %0t", irq_out, exp_irq, $time);
      end
      if (rd) begin
        checks++;
        if (rdata !== exp_read(int'(addr) / 4)) begin
          errors++;
          $display("FAIL %s: read idx %0d got %h exp %h at %0t", tag_of(int'(addr) / 4),
                   int'(addr) / 4, rdata, exp_read(int'(addr) / 4), $time);
        end
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr_reg(int widx, logic [DW-1:0] val);
    @(negedge clk); #1;
    wr = 1'b1; rd = 1'b1; addr = AW'(widx * 4); wdata = val;
    @(negedge clk); #1;
    wr = 1'b0; rd = 1'b0;
  endtask

  task automatic expect_rd(int widx, logic [DW-1:0] exp, string tag);
    @(negedge clk); #1;
    rd = 1'b1; addr = AW'(widx * 4) | AW'(widx % 4);
    #4;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s: idx %0d got %h exp %h", tag, widx, rdata, exp);
    end
    rd = 1'b0;
  endtask

  task automatic expect_irq(logic exp, string tag);
    @(negedge clk); #5;
    checks++;
    if (irq_out !== exp) begin
      errors++;
      $display("FAIL %s: irq_out got %b exp %b", tag, irq_out, exp);
    end
  endtask

  task automatic set_in(logic [N-1:0] v);
    @(negedge clk); #1;
    irq_in = v;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      finish_run();
    end
  end

  initial begin
    cyc(4);
    @(negedge clk); #1; rst_n = 1'b1;

    // R1: reset state
    expect_rd(0, 32'h0, "R1");
    expect_rd(2, 32'h0, "R1");
    expect_rd(7, 32'h0, "R1");
    expect_rd(6, 32'hFFFF_FFFF, "R1");
    expect_irq(1'b0, "R1");

    // R10: status writable while capture is off; R5/R6/R7/R9 on the result
    wr_reg(0, 32'h5);
    expect_rd(0, 32'h5, "R10");
    expect_rd(1, 32'h0, "R5");
    wr_reg(4, 32'h4);
    expect_rd(1, 32'h4, "R5");
    expect_rd(6, 32'd2, "R6");
    expect_irq(1'b0, "R7");
    wr_reg(7, 32'h1);
    expect_irq(1'b1, "R7");
    wr_reg(5, 32'h4);
    expect_rd(2, 32'h0, "R9");
    expect_irq(1'b0, "R7");
    wr_reg(4, 32'h8000_0001);
    expect_rd(6, 32'd0, "R6");
    wr_reg(3, 32'h1);
    expect_rd(6, 32'hFFFF_FFFF, "R6");
    wr_reg(0, 32'h8000_0004);
    expect_rd(6, 32'd31, "R6");
    wr_reg(2, 32'h8000_0001);
    expect_rd(2, 32'h8000_0001, "R9");

    // R10: status write ignored once capture is on; R2 alias reads
    wr_reg(3, 32'hFFFF_FFFF);
    wr_reg(7, 32'h3);
    wr_reg(0, 32'hF);
    expect_rd(0, 32'h0, "R10");
    expect_rd(3, 32'h0, "R2");
    expect_rd(4, 32'h0, "R2");
    expect_rd(5, 32'h0, "R2");
    expect_rd(7, 32'h3, "R2");

    // R11: writes to pending, vector and out-of-range indices do nothing
    wr_reg(8, 32'hFFFF_FFFF);
    wr_reg(1, 32'hFFFF_FFFF);
    wr_reg(6, 32'h0);
    wr_reg(63, 32'hFFFF_FFFF);
    expect_rd(8, 32'h0, "R11");
    expect_rd(2, 32'h8000_0001, "R11");
    expect_rd(0, 32'h0, "R11");
    expect_rd(6, 32'hFFFF_FFFF, "R11");

    // R12/R3: level line latency and re-capture after acknowledge
    wr_reg(4, 32'hFFFF_FFFF);
    set_in(32'h8);
    expect_rd(0, 32'h0, "R12");
    expect_rd(0, 32'h0, "R12");
    expect_rd(0, 32'h8, "R12");
    expect_irq(1'b1, "R3");
    wr_reg(3, 32'h8);
    expect_rd(0, 32'h8, "R3");
    set_in(32'h0);
    cyc(3);
    wr_reg(3, 32'h8);
    expect_rd(0, 32'h0, "R8");

    // R4: edge line captured once, not while held, lost while capture is off
    set_in(32'h0010_0000);
    cyc(4);
    expect_rd(0, 32'h0010_0000, "R4");
    wr_reg(3, 32'h0010_0000);
    cyc(3);
    expect_rd(0, 32'h0, "R4");
    set_in(32'h0);
    cyc(3);
    wr_reg(7, 32'h1);
    set_in(32'h0020_0000);
    cyc(4);
    expect_rd(0, 32'h0, "R4");
    wr_reg(7, 32'h3);
    cyc(4);
    expect_rd(0, 32'h0, "R4");
    set_in(32'h0);
    cyc(3);

    // R8: acknowledge swept across the capture edge; offset 1 collides
    for (int d = 0; d < 4; d++) begin
      set_in(32'h0040_0000);
      cyc(d);
      wr_reg(3, 32'h0040_0000);
      set_in(32'h0);
      if (d == 1) expect_rd(0, 32'h0040_0000, "R8");
      cyc(4);
      wr_reg(3, 32'hFFFF_FFFF);
      cyc(2);
    end

    // Mixed traffic against the model on every clock
    for (int k = 0; k < 1500; k++) begin
      @(negedge clk); #1;
      if (($urandom % 6) == 0) irq_in = irq_in ^ (N'(1) << ($urandom % N));
      wr    = (($urandom % 4) == 0);
      rd    = (($urandom % 2) == 0);
      addr  = AW'((($urandom % 10) * 4) + ($urandom % 4));
      wdata = ((int'(addr) / 4) == 7) ? DW'($urandom % 4) : DW'($urandom);
    end
    @(negedge clk); #1;
    wr = 1'b0; rd = 1'b0;
    cyc(4);
    finish_run();
  end

endmodule